// File: doc/BRIEF.md
# Address-Match Breakpoint Controller

This block watches the fetch side of a small 8-bit processor's 16-bit address bus and asks the core for a break interrupt. A break comes either from a fetch whose address equals a programmed break address, or from software setting the active bit by hand. When a break is taken, the core is handed a fixed vector. While the break lasts, the block freezes the timer, blocks input captures, optionally turns off the watchdog, and controls whether module status flags may be cleared.

Where the match lands decides the timing. A hit on an opcode fetch takes the break at once, so that instruction does not run. A hit on an operand fetch waits for the current instruction to finish, which the core signals with a boundary strobe. A software-forced break also waits for that strobe. A consumed match disarms the comparator. It stays disarmed until software writes one of the address bytes again, so returning from the routine to the same address does not cause another break.

Registers sit on a simple write/read port with combinational read data. The break address is kept as one byte per offset, most significant byte first, followed by a control register and an auxiliary register.

Top module: `brk_ctrl`

## Requirements
- R1: After reset every register reads 0. `brk_req`, `tmr_freeze`, `icap_inhibit` and `wdog_off` are 0, `flag_clr_en` is 1, and the comparator is armed.
- R2: Register offsets are as follows. Offset 0 holds break-address bits 15:8 and offset 1 holds bits 7:0. Offset 2 is control: bit 7 is match enable and bit 6 is break active. Offset 3 is auxiliary: bit 0 permits flag clearing during a break and bit 1 permits watchdog disable. Written fields read back.
- R3: A match needs `fetch_vld`, the enable bit, and equality of both the high and the low address byte. A single byte agreeing is not enough.
- R4: A match on an opcode fetch (`fetch_opcode`=1) raises `brk_req` for exactly one cycle, starting at the next clock edge, and sets the active bit at that same edge.
- R5: A match on an operand fetch (`fetch_opcode`=0) takes no break until the edge at which `insn_done` is sampled high.
- R6: Writing 1 to the active bit when no break is active takes a break at the next edge where `insn_done` is high, and not before.
- R7: Once a match has been consumed, fetches at the same address take no break until an address byte register is written.
- R8: `brk_vec` is 16'hFFFC when `monitor_mode` is 0 and 16'hFEFC when it is 1.
- R9: `tmr_freeze` and `icap_inhibit` are high exactly while the active bit is set.
- R10: `wdog_off` is high only while a break is active, `monitor_mode` is 1 and auxiliary bit 1 is set.
- R11: `flag_clr_en` is 1 outside a break. During a break it equals auxiliary bit 0.
- R12: Writing 0 to the active bit ends a break and cancels any deferred or forced break still waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| fetch_vld | input | 1 | A fetch is on the address bus this cycle |
| fetch_opcode | input | 1 | 1: opcode fetch, 0: operand fetch |
| fetch_addr | input | 16 | Fetch address |
| insn_done | input | 1 | Instruction boundary strobe |
| monitor_mode | input | 1 | Core is in monitor mode |
| brk_req | output | 1 | One-cycle break interrupt request |
| brk_vec | output | 16 | Break vector address |
| tmr_freeze | output | 1 | Stop timer counter |
| icap_inhibit | output | 1 | Block input captures |
| wdog_off | output | 1 | Disable watchdog |
| flag_clr_en | output | 1 | Status flags may be cleared |

## Verification
The hardest situations to reach are a deferred break held pending across idle cycles and the disarmed state after a consumed match. Neither can be seen directly at the ports. The bench places an operand-fetch hit and holds `insn_done` low for several cycles before raising it, checking `brk_req` on each edge. It then clears the active bit without touching the address registers and replays the same opcode fetch, to show that no break follows until an address byte is rewritten. A forced break is cancelled before its boundary arrives, to show that the pending request is dropped.

// File: rtl/brk_pkg.sv
package brk_pkg;
  localparam int CTL_EN_BIT  = 7;
  localparam int CTL_ACT_BIT = 6;
  localparam int AUX_FC_BIT  = 0;
  localparam int AUX_WD_BIT  = 1;
  localparam logic [15:0] VEC_NORMAL  = 16'hFFFC;
  localparam logic [15:0] VEC_MONITOR = 16'hFEFC;
endpackage

// File: rtl/brk_cmp.sv
module brk_cmp #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         eq
);
  assign eq = (a == b);
endmodule

// File: rtl/brk_regs.sv
module brk_regs
  import brk_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BYTE_W = 8,
  localparam int NB    = ADDR_W / BYTE_W,
  localparam int RAW   = $clog2(NB + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [RAW-1:0]    addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  input  logic              active,
  output logic [ADDR_W-1:0] bp_addr,
  output logic              enable,
  output logic              fc_permit,
  output logic              wd_permit,
  output logic              addr_wr,
  output logic              ctl_wr,
  output logic              ctl_act
);
  logic [ADDR_W-1:0] bp_q, bp_n;
  logic              en_q, en_n, fc_q, fc_n, wd_q, wd_n;
  logic              unused_wdata;

  assign unused_wdata = ^wdata;

  always_comb begin
    bp_n    = bp_q;
    en_n    = en_q;
    fc_n    = fc_q;
    wd_n    = wd_q;
    addr_wr = 1'b0;
    ctl_wr  = 1'b0;
    if (wr) begin
      for (int k = 0; k < NB; k++) begin
        if (addr == RAW'(k)) begin
          bp_n[(NB-1-k)*BYTE_W +: BYTE_W] = wdata;
          addr_wr = 1'b1;
        end
      end
      if (addr == RAW'(NB)) begin
        en_n   = wdata[CTL_EN_BIT];
        ctl_wr = 1'b1;
      end
      if (addr == RAW'(NB + 1)) begin
        fc_n = wdata[AUX_FC_BIT];
        wd_n = wdata[AUX_WD_BIT];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bp_q <= '0;
      en_q <= 1'b0;
      fc_q <= 1'b0;
      wd_q <= 1'b0;
    end else if (wr) begin
      bp_q <= bp_n;
      en_q <= en_n;
      fc_q <= fc_n;
      wd_q <= wd_n;
    end
  end

  always_comb begin
    rdata = '0;
    for (int k = 0; k < NB; k++) begin
      if (addr == RAW'(k)) rdata = bp_q[(NB-1-k)*BYTE_W +: BYTE_W];
    end
    if (addr == RAW'(NB)) begin
      rdata[CTL_EN_BIT]  = en_q;
      rdata[CTL_ACT_BIT] = active;
    end
    if (addr == RAW'(NB + 1)) begin
      rdata[AUX_FC_BIT] = fc_q;
      rdata[AUX_WD_BIT] = wd_q;
    end
  end

  assign ctl_act   = wdata[CTL_ACT_BIT];
  assign bp_addr   = bp_q;
  assign enable    = en_q;
  assign fc_permit = fc_q;
  assign wd_permit = wd_q;

  // R2
  reg_wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(bp_addr) && $stable(enable));
endmodule

// File: rtl/brk_seq.sv
module brk_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic fetch_opcode,
  input  logic insn_done,
  input  logic addr_wr,
  input  logic ctl_wr,
  input  logic ctl_act,
  output logic active,
  output logic brk_req
);
  logic act_q, act_n, pend_q, pend_n, arm_q, arm_n, req_q, req_n;
  logic hit_ok, sw_clr, sw_force, take_op, take_def, take;

  always_comb begin
    hit_ok   = hit && arm_q && !act_q && !pend_q;
    sw_clr   = ctl_wr && !ctl_act;
    sw_force = ctl_wr && ctl_act && !act_q;
    take_op  = hit_ok && fetch_opcode;
    take_def = pend_q && insn_done;
    take     = !sw_clr && (take_op || take_def);

    req_n = take;

    act_n = act_q;
    if (sw_clr)    act_n = 1'b0;
    else if (take) act_n = 1'b1;

    pend_n = pend_q;
    if (sw_clr || take)                          pend_n = 1'b0;
    else if (sw_force || (hit_ok && !fetch_opcode)) pend_n = 1'b1;

    arm_n = arm_q;
    if (addr_wr)                arm_n = 1'b1;
    else if (hit_ok && !sw_clr) arm_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      pend_q <= 1'b0;
      arm_q  <= 1'b1;
      req_q  <= 1'b0;
    end else begin
      act_q  <= act_n;
      pend_q <= pend_n;
      arm_q  <= arm_n;
      req_q  <= req_n;
    end
  end

  assign active  = act_q;
  assign brk_req = req_q;

  // R4
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req |=> !brk_req);

  // R7
  disarm_on_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(arm_q) |-> (brk_req || pend_q));

  // R12
  sw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && !ctl_act) |=> !active && !brk_req);
endmodule

// File: rtl/brk_ctrl.sv
module brk_ctrl
  import brk_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BYTE_W = 8,
  localparam int NB    = ADDR_W / BYTE_W,
  localparam int RAW   = $clog2(NB + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [RAW-1:0]    reg_addr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  input  logic              fetch_vld,
  input  logic              fetch_opcode,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic              insn_done,
  input  logic              monitor_mode,
  output logic              brk_req,
  output logic [15:0]       brk_vec,
  output logic              tmr_freeze,
  output logic              icap_inhibit,
  output logic              wdog_off,
  output logic              flag_clr_en
);
  logic [1:0]        rst_sync;
  logic              srst_n;
  logic [ADDR_W-1:0] bp_addr;
  logic [NB-1:0]     byte_eq;
  logic              enable, fc_permit, wd_permit, addr_wr, ctl_wr, ctl_act;
  logic              active, hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign srst_n = rst_sync[1];

  brk_regs #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_regs (
    .clk(clk), .rst_n(srst_n), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .active(active),
    .bp_addr(bp_addr), .enable(enable), .fc_permit(fc_permit),
    .wd_permit(wd_permit), .addr_wr(addr_wr), .ctl_wr(ctl_wr),
    .ctl_act(ctl_act)
  );

  for (genvar g = 0; g < NB; g++) begin : g_cmp
    brk_cmp #(.W(BYTE_W)) u_cmp (
      .a(fetch_addr[g*BYTE_W +: BYTE_W]),
      .b(bp_addr[g*BYTE_W +: BYTE_W]),
      .eq(byte_eq[g])
    );
  end

  assign hit = fetch_vld && enable && (&byte_eq);

  brk_seq u_seq (
    .clk(clk), .rst_n(srst_n), .hit(hit), .fetch_opcode(fetch_opcode),
    .insn_done(insn_done), .addr_wr(addr_wr), .ctl_wr(ctl_wr),
    .ctl_act(ctl_act), .active(active), .brk_req(brk_req)
  );

  assign brk_vec      = monitor_mode ? VEC_MONITOR : VEC_NORMAL;
  assign tmr_freeze   = active;
  assign icap_inhibit = active;
  assign wdog_off     = active && monitor_mode && wd_permit;
  assign flag_clr_en  = !active || fc_permit;

  // R9
  req_freezes_chk: assert property (@(posedge clk) disable iff (!srst_n)
    brk_req |-> tmr_freeze && icap_inhibit);

  // R10
  wdog_in_break_chk: assert property (@(posedge clk) disable iff (!srst_n)
    wdog_off |-> tmr_freeze && monitor_mode);

  // R11
  flag_outside_chk: assert property (@(posedge clk) disable iff (!srst_n)
    !tmr_freeze |-> flag_clr_en);
endmodule

// File: tb/sim_brk_ctrl.sv
module sim_brk_ctrl;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [1:0]  reg_addr;
  logic [7:0]  reg_wdata;
  logic [7:0]  reg_rdata;
  logic        fetch_vld, fetch_opcode, insn_done, monitor_mode;
  logic [15:0] fetch_addr;
  logic        brk_req, tmr_freeze, icap_inhibit, wdog_off, flag_clr_en;
  logic [15:0] brk_vec;

  int total = 0;
  int bad   = 0;

  always #(PERIOD/2) clk = ~clk;

  brk_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fetch_vld(fetch_vld),
    .fetch_opcode(fetch_opcode), .fetch_addr(fetch_addr),
    .insn_done(insn_done), .monitor_mode(monitor_mode), .brk_req(brk_req),
    .brk_vec(brk_vec), .tmr_freeze(tmr_freeze), .icap_inhibit(icap_inhibit),
    .wdog_off(wdog_off), .flag_clr_en(flag_clr_en)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [1:0] a, input logic [7:0] exp);
    reg_addr = a;
    #1;
    check(req, 32'(reg_rdata), 32'(exp));
  endtask

  task automatic fetch(input logic [15:0] a, input logic opc, input logic vld);
    fetch_vld = vld; fetch_opcode = opc; fetch_addr = a;
    tick();
    fetch_vld = 1'b0;
  endtask

  task automatic boundary();
    insn_done = 1'b1;
    tick();
    insn_done = 1'b0;
  endtask

  task automatic t_reset();
    for (int a = 0; a < 4; a++) rd_chk("R1", 2'(a), 8'h00);
    check("R1", 32'(brk_req), 0);
    check("R1", 32'(tmr_freeze), 0);
    check("R1", 32'(icap_inhibit), 0);
    check("R1", 32'(wdog_off), 0);
    check("R1", 32'(flag_clr_en), 1);
    check("R8", 32'(brk_vec), 32'h0000FFFC);
  endtask

  task automatic t_regs();
    wr(2'd3, 8'h03); rd_chk("R2", 2'd3, 8'h03);
    wr(2'd3, 8'h00); rd_chk("R2", 2'd3, 8'h00);
    wr(2'd0, 8'h12); wr(2'd1, 8'h34);
    rd_chk("R2", 2'd0, 8'h12); rd_chk("R2", 2'd1, 8'h34);
    wr(2'd2, 8'h80); rd_chk("R2", 2'd2, 8'h80);
  endtask

  task automatic t_opcode();
    fetch(16'h1234, 1'b1, 1'b1);
    check("R4", 32'(brk_req), 1);
    rd_chk("R4", 2'd2, 8'hC0);
    check("R9", 32'(tmr_freeze), 1);
    check("R9", 32'(icap_inhibit), 1);
    check("R11", 32'(flag_clr_en), 0);
    tick();
    check("R4", 32'(brk_req), 0);
    check("R9", 32'(tmr_freeze), 1);
    wr(2'd2, 8'h80);
    check("R12", 32'(tmr_freeze), 0);
    rd_chk("R12", 2'd2, 8'h80);
    check("R11", 32'(flag_clr_en), 1);
  endtask

  task automatic t_rearm();
    fetch(16'h1234, 1'b1, 1'b1);
    check("R7", 32'(brk_req), 0);
    rd_chk("R7", 2'd2, 8'h80);
    wr(2'd1, 8'h34);
    fetch(16'h1234, 1'b1, 1'b1);
    check("R7", 32'(brk_req), 1);
    wr(2'd2, 8'h80);
  endtask

  task automatic t_partial();
    wr(2'd1, 8'h35);
    fetch(16'h1234, 1'b1, 1'b1);
    check("R3", 32'(brk_req), 0);
    fetch(16'h1335, 1'b1, 1'b1);
    check("R3", 32'(brk_req), 0);
    fetch(16'h1235, 1'b1, 1'b0);
    check("R3", 32'(brk_req), 0);
    wr(2'd2, 8'h00);
    fetch(16'h1235, 1'b1, 1'b1);
    check("R3", 32'(brk_req), 0);
    wr(2'd2, 8'h80);
    fetch(16'h1235, 1'b1, 1'b1);
    check("R3", 32'(brk_req), 1);
    wr(2'd2, 8'h80);
    wr(2'd1, 8'h35);
  endtask

  task automatic t_operand();
    fetch(16'h1235, 1'b0, 1'b1);
    check("R5", 32'(brk_req), 0);
    rd_chk("R5", 2'd2, 8'h80);
    for (int i = 0; i < 3; i++) begin
      tick();
      check("R5", 32'(brk_req), 0);
    end
    boundary();
    check("R5", 32'(brk_req), 1);
    rd_chk("R5", 2'd2, 8'hC0);
    wr(2'd2, 8'h80);
  endtask

  task automatic t_force();
    wr(2'd2, 8'hC0);
    check("R6", 32'(brk_req), 0);
    rd_chk("R6", 2'd2, 8'h80);
    tick();
    check("R6", 32'(brk_req), 0);
    boundary();
    check("R6", 32'(brk_req), 1);
    rd_chk("R6", 2'd2, 8'hC0);
    wr(2'd2, 8'h80);
  endtask

  task automatic t_cancel();
    wr(2'd2, 8'hC0);
    wr(2'd2, 8'h80);
    boundary();
    check("R12", 32'(brk_req), 0);
    rd_chk("R12", 2'd2, 8'h80);
  endtask

  task automatic t_monitor();
    monitor_mode = 1'b1;
    wr(2'd3, 8'h02);
    check("R8", 32'(brk_vec), 32'h0000FEFC);
    check("R10", 32'(wdog_off), 0);
    wr(2'd2, 8'hC0);
    boundary();
    check("R10", 32'(wdog_off), 1);
    check("R11", 32'(flag_clr_en), 0);
    wr(2'd3, 8'h03);
    check("R11", 32'(flag_clr_en), 1);
    monitor_mode = 1'b0;
    #1;
    check("R10", 32'(wdog_off), 0);
    check("R8", 32'(brk_vec), 32'h0000FFFC);
    monitor_mode = 1'b1;
    wr(2'd3, 8'h01);
    check("R10", 32'(wdog_off), 0);
    wr(2'd2, 8'h80);
    check("R9", 32'(icap_inhibit), 0);
    monitor_mode = 1'b0;
  endtask

  initial begin
    #(PERIOD * 50000);
    bad++;
    total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    fetch_vld = 1'b0; fetch_opcode = 1'b0; fetch_addr = '0;
    insn_done = 1'b0; monitor_mode = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (3) tick();
    t_reset();
    t_regs();
    t_opcode();
    t_rearm();
    t_partial();
    t_operand();
    t_force();
    t_cancel();
    t_monitor();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule